// File: doc/BRIEF.md
# MXFP4 Block Quantizer

This block turns a stream of BF16 numbers into packed 4-bit microscaling blocks. It takes one BF16 value per cycle over a valid/ready input with a last marker. It collects a group of 32 values and finds the largest exponent among them. From that exponent it picks a power-of-two shared scale. Each element is then divided by the scale and rounded onto the signed E2M1 grid {0, 0.5, 1, 1.5, 2, 3, 4, 6}. The result is presented as a 128-bit code word plus an 8-bit E8M0 scale on a valid/ready output.

The collection buffer and the output register are separate. The next group can therefore stream in while a finished group waits on a stalled consumer. A group with a NaN is marked by the reserved scale code. A group with no nonzero value gives scale zero and an all-zero code word.

Top module: `mxfp4_block_quant`

## Requirements
- R1: A group closes on its 32nd accepted beat, or earlier on an accepted beat with `in_last` high. Positions not filled in an early-closed group count as +0. Once a group has closed, `in_ready` stays low until that group has been moved into the output register.
- R2: Element i of the group is placed in `out_data[4i+3:4i]`. Each nibble is {sign, 2-bit exponent, 1-bit mantissa}, and magnitude codes 0..7 stand for 0, 0.5, 1, 1.5, 2, 3, 4 and 6.
- R3: Let E be the largest biased BF16 exponent field among the nonzero elements. `out_scale` is E−2, or 0 when E is below 2. This is the unbiased shared exponent floor(log2 max|x|)−2, clamped at −127, with bias 127.
- R4: Each element divided by 2^(out_scale−127) is rounded to the nearest grid magnitude. A tie goes to the even magnitude code (mantissa bit 0).
- R5: A scaled magnitude of 0.25 or less gives magnitude code 0 while the sign bit is kept.
- R6: A scaled magnitude above 6, or an infinite input, gives magnitude code 7 with its sign.
- R7: A group in which every element is zero or a BF16 subnormal (exponent field 0) gives `out_scale` 0 and `out_data` 0.
- R8: A group with any NaN input (exponent field all ones, mantissa nonzero) gives `out_scale` 8'hFF and `out_data` 0. No other group produces a scale above 253.
- R9: If the output register is empty when a group closes, `out_valid` rises on the second rising edge after the closing beat's edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_scale` hold. The next group can be accepted in the meantime.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 16 | BF16 element |
| in_last | input | 1 | Beat closes the group |
| out_valid | output | 1 | Packed group available |
| out_ready | input | 1 | Consumer takes the packed group |
| out_data | output | 128 | 32 E2M1 codes, element 0 in the low nibble |
| out_scale | output | 8 | E8M0 shared scale |

## Verification
The bench goes after exact rounding ties at every step size, and after the 0.25 deadzone boundary with negative inputs. A design that rounded ties away from zero, or dropped the sign of small values, would return wrong nibbles for those elements. Several further cases each produce a wrong scale or stray nonzero codes if handled wrongly:
- exponent fields 1 and 2, where the scale must clamp;
- infinite and above-6 inputs, which must saturate;
- all-zero and subnormal-only groups;
- groups containing a NaN.

Early closing by the last marker is checked against zero padding. A stalled output with a second group queued behind it is also checked: lost or changed data there means the buffer and output stages are not properly decoupled.

// File: rtl/mxq_pkg.sv
package mxq_pkg;
   localparam int unsigned BF_W    = 16;
   localparam int unsigned EXP_W   = 8;
   localparam int unsigned MAN_W   = 7;
   localparam int unsigned CODE_W  = 4;
   localparam int unsigned SCALE_W = 8;
   localparam logic [SCALE_W-1:0] SCALE_NAN = 8'hFF;
   localparam logic [EXP_W-1:0]   EXP_ONES  = 8'hFF;

   typedef struct packed {
      logic             sgn;
      logic [EXP_W-1:0] expo;
      logic [MAN_W-1:0] man;
   } bf16_t;
endpackage

// File: rtl/mxq_collect.sv
module mxq_collect
   import mxq_pkg::*;
#(
   parameter int unsigned N_ELEM = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [BF_W-1:0]          in_data,
   input  logic                     in_last,
   input  logic                     drain,
   output logic                     in_ready,
   output logic                     full,
   output logic [N_ELEM*BF_W-1:0]   buf_flat,
   output logic [EXP_W-1:0]         emax,
   output logic                     has_nan
);
   localparam int unsigned CNT_W = $clog2(N_ELEM);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(N_ELEM - 1);

   logic [BF_W-1:0]  slot_q [N_ELEM];
   logic [CNT_W-1:0] cnt_q;
   bf16_t            beat;

   assign beat     = bf16_t'(in_data);
   assign in_ready = !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         full    <= 1'b0;
         emax    <= '0;
         has_nan <= 1'b0;
         for (int i = 0; i < N_ELEM; i++) slot_q[i] <= '0;
      end else if (drain) begin
         cnt_q   <= '0;
         full    <= 1'b0;
         emax    <= '0;
         has_nan <= 1'b0;
         for (int i = 0; i < N_ELEM; i++) slot_q[i] <= '0;
      end else if (in_valid && !full) begin
         slot_q[cnt_q] <= in_data;
         cnt_q         <= cnt_q + 1'b1;
         if (beat.expo == EXP_ONES && beat.man != '0) has_nan <= 1'b1;
         if (beat.expo > emax) emax <= beat.expo;
         if (in_last || cnt_q == CNT_TOP) full <= 1'b1;
      end
   end

   for (genvar g = 0; g < N_ELEM; g++) begin : g_flat
      assign buf_flat[g*BF_W +: BF_W] = slot_q[g];
   end
endmodule

// File: rtl/mxq_scale.sv
module mxq_scale
   import mxq_pkg::*;
(
   input  logic [EXP_W-1:0]   emax,
   output logic [SCALE_W-1:0] scale_code,
   output logic               any_nz
);
   localparam logic [EXP_W-1:0] GRID_TOP = 8'd2;

   assign any_nz     = |emax;
   assign scale_code = (emax >= GRID_TOP) ? SCALE_W'(emax - GRID_TOP) : '0;
endmodule

// File: rtl/mxq_elem_enc.sv
module mxq_elem_enc
   import mxq_pkg::*;
(
   input  logic [BF_W-1:0]    elem,
   input  logic [SCALE_W-1:0] scale_code,
   output logic [CODE_W-1:0]  code
);
   bf16_t             x;
   logic signed [9:0] d;
   logic              up;
   logic [3:0]        nrm;
   logic [2:0]        mag;

   assign x = bf16_t'(elem);
   assign d = $signed({2'b00, x.expo}) - $signed({2'b00, scale_code});

   always_comb begin
      up  = x.man[5] & (x.man[6] | (|x.man[4:0]));
      nrm = {1'b0, d[1:0] + 2'd1, x.man[6]} + {3'b000, up};
      if (x.expo == '0)            mag = 3'd0;
      else if (x.expo == EXP_ONES) mag = 3'd7;
      else if (d > 10'sd2)         mag = 3'd7;
      else if (d >= 10'sd0)        mag = nrm[3] ? 3'd7 : nrm[2:0];
      else if (d == -10'sd1)       mag = x.man[6] ? 3'd2 : 3'd1;
      else if (d == -10'sd2)       mag = (|x.man) ? 3'd1 : 3'd0;
      else                         mag = 3'd0;
   end

   assign code = {x.sgn, mag};
endmodule

// File: rtl/mxfp4_block_quant.sv
module mxfp4_block_quant
   import mxq_pkg::*;
#(
   parameter int unsigned N_ELEM = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [15:0]                in_data,
   input  logic                       in_last,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [N_ELEM*4-1:0]        out_data,
   output logic [7:0]                 out_scale
);
   localparam int unsigned DATA_W = N_ELEM * CODE_W;

   if (N_ELEM < 2) begin : g_bad_count
      $error("mxfp4_block_quant: N_ELEM must be at least 2");
   end
   if (BF_W != 16 || CODE_W != 4) begin : g_bad_format
      $error("mxfp4_block_quant: element formats are fixed");
   end

   logic                     full, has_nan, any_nz, load;
   logic [N_ELEM*BF_W-1:0]   buf_flat;
   logic [EXP_W-1:0]         emax;
   logic [SCALE_W-1:0]       scale_code;
   logic [DATA_W-1:0]        enc_flat;

   assign load = full && (!out_valid || out_ready);

   mxq_collect #(.N_ELEM(N_ELEM)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .drain    (load),
      .in_ready (in_ready),
      .full     (full),
      .buf_flat (buf_flat),
      .emax     (emax),
      .has_nan  (has_nan)
   );

   mxq_scale u_scale (
      .emax       (emax),
      .scale_code (scale_code),
      .any_nz     (any_nz)
   );

   for (genvar g = 0; g < N_ELEM; g++) begin : g_enc
      mxq_elem_enc u_enc (
         .elem       (buf_flat[g*BF_W +: BF_W]),
         .scale_code (scale_code),
         .code       (enc_flat[g*CODE_W +: CODE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_scale <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= (has_nan || !any_nz) ? '0 : enc_flat;
         out_scale <= has_nan ? SCALE_NAN : scale_code;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/mxq_checker.sv
module mxq_checker #(
   parameter int unsigned N_ELEM = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_last,
   input logic                out_valid,
   input logic                out_ready,
   input logic [N_ELEM*4-1:0] out_data,
   input logic [7:0]          out_scale
);
   localparam int unsigned BC_W = $clog2(N_ELEM) + 1;

   logic [BC_W-1:0] beat_cnt;
   logic            closing;

   assign closing = in_valid && in_ready && (in_last || beat_cnt == BC_W'(N_ELEM - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   beat_cnt <= '0;
      else if (closing)             beat_cnt <= '0;
      else if (in_valid && in_ready) beat_cnt <= beat_cnt + 1'b1;
   end

   assert_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> !in_ready);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_scale)));

   assert_nan_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_scale == 8'hFF) |-> (out_data == '0));

   assert_scale_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_scale <= 8'd253 || out_scale == 8'hFF));

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (closing && !out_valid) |=> !out_valid ##1 out_valid);

   assert_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind mxfp4_block_quant mxq_checker #(.N_ELEM(N_ELEM)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_scale (out_scale)
);

// File: tb/tb_mxfp4_block_quant.sv
module tb_mxfp4_block_quant;
   localparam int N  = 32;
   localparam int DW = N * 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_ready, in_last;
   logic [15:0]   in_data;
   logic          out_valid, out_ready;
   logic [DW-1:0] out_data;
   logic [7:0]    out_scale;

   always #5 clk = ~clk;

   mxfp4_block_quant #(.N_ELEM(N)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_scale(out_scale)
   );

   int n_vec = 0;
   int n_fail = 0;
   logic [DW+7:0] exp_q [$];
   string         tag_q [$];
   logic [15:0]   blk [N];
   int unsigned   rs = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input logic [DW+7:0] act, input logic [DW+7:0] expv);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic real pow2(input int k);
      real r = 1.0;
      if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
      else        for (int i = 0; i < -k; i++) r = r / 2.0;
      return r;
   endfunction

   function automatic logic [15:0] mk(input real v);
      real a;
      int  e;
      logic s;
      int  m;
      s = (v < 0.0);
      a = s ? -v : v;
      if (a == 0.0) return {s, 15'd0};
      e = 127;
      while (a >= 2.0) begin a = a / 2.0; e++; end
      while (a < 1.0)  begin a = a * 2.0; e--; end
      m = $rtoi((a - 1.0) * 128.0);
      return {s, 8'(e), 7'(m)};
   endfunction

   function automatic logic [DW+7:0] model(input int n);
      logic [15:0]   w;
      int            emax = 0;
      bit            nan = 0;
      int            sc;
      logic [DW-1:0] d = '0;
      real           grid [8];
      real           v, bd, df;
      int            best;
      grid[0] = 0.0; grid[1] = 0.5; grid[2] = 1.0; grid[3] = 1.5;
      grid[4] = 2.0; grid[5] = 3.0; grid[6] = 4.0; grid[7] = 6.0;
      for (int i = 0; i < N; i++) begin
         w = (i < n) ? blk[i] : 16'h0000;
         if (w[14:7] == 8'hFF && w[6:0] != 0) nan = 1;
         if (int'(w[14:7]) > emax) emax = int'(w[14:7]);
      end
      if (nan)       return {8'hFF, {DW{1'b0}}};
      if (emax == 0) return '0;
      sc = (emax >= 2) ? emax - 2 : 0;
      for (int i = 0; i < N; i++) begin
         w = (i < n) ? blk[i] : 16'h0000;
         if (w[14:7] == 0) best = 0;
         else if (w[14:7] == 8'hFF) best = 7;
         else begin
            v = (1.0 + real'(int'(w[6:0])) / 128.0) * pow2(int'(w[14:7]) - sc);
            best = 0; bd = v;
            for (int k = 1; k < 8; k++) begin
               df = (v > grid[k]) ? v - grid[k] : grid[k] - v;
               if (df < bd || (df == bd && (k % 2) == 0)) begin best = k; bd = df; end
            end
         end
         d[4*i +: 4] = {w[15], 3'(best)};
      end
      return {8'(sc), d};
   endfunction

   task automatic send_block(input int n, input bit lst, input string tag);
      exp_q.push_back(model(n));
      tag_q.push_back(tag);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_data  = blk[i];
         in_last  = lst && (i == n - 1);
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic clear_blk();
      for (int i = 0; i < N; i++) blk[i] = 16'h0000;
   endtask

   function automatic int unsigned rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) chk(1'b0, "R9 unexpected group", {out_scale, out_data}, '0);
         else begin
            logic [DW+7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({out_scale, out_data} == e, t, {out_scale, out_data}, e);
         end
      end
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [DW+7:0] held;
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R11 reset state", {out_valid, in_ready}, 2'b01);
      @(posedge clk); #1;

      // ramp 1..32, output idle: also latency (R9)
      for (int i = 0; i < N; i++) blk[i] = mk(real'(i + 1));
      send_block(N, 1'b1, "R2 R3 R4 ramp");
      @(negedge clk);
      chk(!out_valid, "R9 not yet valid", out_valid, 0);
      @(negedge clk);
      chk(out_valid, "R9 valid after two edges", out_valid, 1);
      @(posedge clk); #1;

      // ties and deadzone, shared scale 127
      clear_blk();
      blk[0] = mk(4.0);   blk[1] = mk(0.25);  blk[2] = mk(0.75);  blk[3] = mk(1.25);
      blk[4] = mk(1.75);  blk[5] = mk(2.5);   blk[6] = mk(3.5);   blk[7] = mk(5.0);
      blk[8] = mk(-0.1);  blk[9] = mk(-0.25); blk[10] = mk(0.3);  blk[11] = mk(-0.75);
      blk[12] = mk(-5.0); blk[13] = mk(6.0);  blk[14] = 16'h8000; blk[15] = mk(0.5);
      send_block(N, 1'b0, "R4 R5 ties and deadzone");

      // saturation above 6 and infinity
      clear_blk();
      blk[0] = mk(7.5); blk[1] = mk(-7.0); blk[2] = mk(4.5); blk[3] = mk(0.3);
      send_block(N, 1'b0, "R6 saturation");
      clear_blk();
      blk[0] = 16'hFF80; blk[1] = mk(1.0e30); blk[2] = mk(-2.0);
      send_block(N, 1'b0, "R6 infinity");

      // clamped scale with tiny exponents
      clear_blk();
      blk[0] = {1'b0, 8'd1, 7'd5}; blk[1] = {1'b1, 8'd2, 7'd64};
      blk[2] = {1'b0, 8'd0, 7'd3}; blk[3] = {1'b0, 8'd1, 7'd96};
      send_block(N, 1'b0, "R3 clamped scale");
      clear_blk();
      blk[5] = {1'b1, 8'd1, 7'd64}; blk[9] = {1'b0, 8'd1, 7'd0};
      send_block(N, 1'b0, "R3 scale code 0 with exponent 1");

      // zero / subnormal-only group
      clear_blk();
      blk[3] = 16'h8000; blk[7] = 16'h0005; blk[20] = 16'h807F;
      send_block(N, 1'b0, "R7 zero group");

      // NaN group
      for (int i = 0; i < N; i++) blk[i] = mk(real'(i) - 10.0);
      blk[17] = 16'h7FC1;
      send_block(N, 1'b0, "R8 NaN group");

      // early close by last marker
      clear_blk();
      blk[0] = mk(3.0); blk[1] = mk(-1.0); blk[2] = mk(0.4); blk[3] = mk(2.9); blk[4] = mk(-12.0);
      send_block(5, 1'b1, "R1 early close");

      // random groups
      for (int b = 0; b < 6; b++) begin
         for (int i = 0; i < N; i++) begin
            int unsigned r;
            r = rnd();
            blk[i] = (r[3:0] == 4'd0) ? 16'h0000 : {r[31], 8'(120 + (r[27:20] % 12)), r[12:6]};
         end
         send_block(N, 1'b0, "R2 R4 random group");
      end

      // backpressure with a second group queued (R10, R1)
      repeat (3) @(posedge clk); #1;
      out_ready = 1'b0;
      for (int i = 0; i < N; i++) blk[i] = mk(real'(i) * 0.37 - 3.0);
      send_block(N, 1'b0, "R10 held group");
      repeat (3) @(negedge clk);
      held = {out_scale, out_data};
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) blk[i] = mk(real'(N - i) * 1.1);
      send_block(N, 1'b0, "R10 queued group");
      @(negedge clk);
      chk(!in_ready, "R1 closed group blocks input", in_ready, 0);
      chk(out_valid && {out_scale, out_data} == held, "R10 output held", {out_scale, out_data}, held);
      @(posedge clk); #1;
      out_ready = 1'b1;

      repeat (10) @(posedge clk);
      chk(exp_q.size() == 0, "R9 all groups delivered", exp_q.size(), 0);
      finish_run();
   end
endmodule